// File: doc/BRIEF.md
# SONET Transmit Overhead Inserter

This block sits in the byte-wide transmit path of an STS-N frame stream (STS-48 by default). User logic supplies one byte per clock and marks the first byte of a frame with a single pulse. After that pulse the block tracks its own position through the frame of 9 rows by 90·N columns, with the first 3·N columns of each row treated as transport overhead. It keeps counting frames without any further pulses.

A mode input sets how much of the overhead the block writes itself. In transparent mode it leaves the overhead alone. In framing-and-parity mode it writes the framing pattern and the parity byte and passes every other byte through. In full-overhead mode it generates all of the overhead. Separate enables, a frame-synchronous scrambler and debug inversion controls refine this behaviour. The finished byte leaves one clock later, together with a frame-start flag and a payload flag.

Configuration inputs are static. They are changed only while reset is held.

Top module: `toh_inserter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_data`, `out_fp` and `out_payload` are all zero.
- R2: Every output lags its input byte by exactly one clock. `out_fp` is high for the byte at row 0, column 0. Before the first `in_fp`, bytes pass through unchanged with `out_fp` and `out_payload` low. After one pulse, `out_fp` recurs every 9·90·N bytes with no further pulses.
- R3: With `cfg_mode` = 0 or 3 (transparent), every byte equals the user byte, apart from scrambling (R7) and debug inversion (R8).
- R4: With `cfg_mode` = 1 and `cfg_a1a2_en` high, row 0 columns 0..N-1 carry 0xF6 and columns N..2N-1 carry 0x28. With `cfg_a1a2_en` low, those slots carry the user bytes.
- R5: With `cfg_mode` = 1 and `cfg_b1_en` high, row 1 column 0 carries the XOR of all output bytes (after scrambling) from the previous frame start up to the current one. This value is 0 in the first frame after the block first locks.
- R6: With `cfg_mode` = 2 (full overhead), every overhead byte is zero except the following:
  - the framing slots, which follow R4 when `cfg_a1a2_en` is high;
  - the parity slot, which follows R5 when `cfg_b1_en` is high.
- R7: With `cfg_scr_en` high, every framed byte except row 0 columns 0..2N-1 is XORed with a key byte.
  - The key comes from a 7-bit register that is set to all ones at row 0 column 2N.
  - For each key bit, MSB first, the key bit is s[6], and then s = {s[5:0], s[6]^s[5]} (x^7+x^6+1).
  - The register advances 8 steps per framed byte.
- R8: Debug inversions are applied before scrambling, in any mode.
  - `dbg_a1a2_inv` inverts the framing slots.
  - `dbg_b1_inv` inverts row 1 column 0.
  - `dbg_k2_inv` inverts row 4 column 2N.
- R9: Once the frame position is known, `out_payload` is high exactly for columns 3N and above.
- R10: An `in_fp` arriving at any later byte restarts the position at row 0 column 0. It also closes the parity window at that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Overhead mode: 0/3 transparent, 1 framing and parity, 2 full overhead |
| cfg_a1a2_en | input | 1 | Enable framing byte insertion |
| cfg_b1_en | input | 1 | Enable parity byte insertion |
| cfg_scr_en | input | 1 | Enable frame-synchronous scrambling |
| dbg_a1a2_inv | input | 1 | Invert framing slots |
| dbg_b1_inv | input | 1 | Invert parity slot |
| dbg_k2_inv | input | 1 | Invert the protection-switch byte slot |
| in_fp | input | 1 | Marks the input byte at row 0, column 0 |
| in_data | input | 8 | Input byte from user logic |
| out_data | output | 8 | Finished byte, one clock after input |
| out_fp | output | 1 | Output byte is row 0, column 0 |
| out_payload | output | 1 | Output byte lies in the payload columns |

## Verification
The properties assume that the configuration inputs hold steady between resets. They also assume that an input byte flagged by `in_fp` is the frame start the user intends. The checks on the framing byte therefore read the mode and enable inputs in the cycle of the pulse. The bench sets every configuration only while reset is asserted. It drives pulses at the frame boundary, or deliberately once mid-frame to exercise realignment, and it models that realignment too.

// File: rtl/toh_pkg.sv
package toh_pkg;

    typedef enum logic [1:0] {
        OH_PASS      = 2'd0,
        OH_FRAME_PAR = 2'd1,
        OH_FULL      = 2'd2,
        OH_PASS_ALT  = 2'd3
    } oh_mode_e;

    localparam logic [7:0] FRAMING_HI = 8'hF6;
    localparam logic [7:0] FRAMING_LO = 8'h28;
    localparam logic [6:0] SCR_SEED   = 7'h7F;
    localparam int         FRAME_ROWS = 9;

    // Decoded role of the byte currently entering the block
    typedef struct packed {
        logic sof;
        logic a1;
        logic a2;
        logic b1;
        logic k2;
        logic scr_reset;
        logic toh;
    } toh_slot_t;

    // Registered output beat
    typedef struct packed {
        logic [7:0] data;
        logic       fp;
        logic       payload;
    } toh_beat_t;

    function automatic logic [7:0] scr_key(input logic [6:0] seed);
        logic [6:0] s;
        logic [7:0] k;
        s = seed;
        k = '0;
        for (int i = 7; i >= 0; i--) begin
            k[i] = s[6];
            s    = {s[5:0], s[6] ^ s[5]};
        end
        return k;
    endfunction

    function automatic logic [6:0] scr_step8(input logic [6:0] seed);
        logic [6:0] s;
        s = seed;
        for (int i = 0; i < 8; i++) s = {s[5:0], s[6] ^ s[5]};
        return s;
    endfunction

endpackage

// File: rtl/toh_locator.sv
module toh_locator
    import toh_pkg::*;
#(
    parameter int N_STS = 48
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      in_fp,
    output logic      active,
    output toh_slot_t slot
);
    localparam int ROW_LEN  = 90 * N_STS;
    localparam int TOH_COLS = 3 * N_STS;
    localparam int COL_W    = $clog2(ROW_LEN);
    localparam int ROW_W    = 4;

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(ROW_LEN - 1);
    localparam logic [COL_W-1:0] C_A2     = COL_W'(N_STS);
    localparam logic [COL_W-1:0] C_AFTER  = COL_W'(2 * N_STS);
    localparam logic [COL_W-1:0] C_TOH    = COL_W'(TOH_COLS);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(FRAME_ROWS - 1);

    logic             locked;
    logic [COL_W-1:0] nxt_col, cur_col;
    logic [ROW_W-1:0] nxt_row, cur_row;

    assign cur_col = in_fp ? '0 : nxt_col;
    assign cur_row = in_fp ? '0 : nxt_row;
    assign active  = in_fp | locked;

    always_comb begin
        slot.sof       = (cur_row == '0) && (cur_col == '0);
        slot.a1        = (cur_row == '0) && (cur_col < C_A2);
        slot.a2        = (cur_row == '0) && (cur_col >= C_A2) && (cur_col < C_AFTER);
        slot.b1        = (cur_row == ROW_W'(1)) && (cur_col == '0);
        slot.k2        = (cur_row == ROW_W'(4)) && (cur_col == C_AFTER);
        slot.scr_reset = (cur_row == '0) && (cur_col == C_AFTER);
        slot.toh       = (cur_col < C_TOH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked  <= 1'b0;
            nxt_col <= '0;
            nxt_row <= '0;
        end else if (active) begin
            locked <= 1'b1;
            if (cur_col == LAST_COL) begin
                nxt_col <= '0;
                nxt_row <= (cur_row == LAST_ROW) ? '0 : cur_row + 1'b1;
            end else begin
                nxt_col <= cur_col + 1'b1;
                nxt_row <= cur_row;
            end
        end
    end
endmodule

// File: rtl/toh_scrambler.sv
module toh_scrambler
    import toh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    input  logic       restart,
    output logic [7:0] key
);
    logic [6:0] st_q, st_use;

    assign st_use = restart ? SCR_SEED : st_q;
    assign key    = scr_key(st_use);

    always_ff @(posedge clk) begin
        if (rst)          st_q <= SCR_SEED;
        else if (advance) st_q <= scr_step8(st_use);
    end
endmodule

// File: rtl/toh_bip8.sv
module toh_bip8 (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       sof,
    input  logic [7:0] byte_in,
    output logic [7:0] parity
);
    logic [7:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            parity <= '0;
        end else if (active) begin
            if (sof) begin
                parity <= acc;
                acc    <= byte_in;
            end else begin
                acc <= acc ^ byte_in;
            end
        end
    end
endmodule

// File: rtl/toh_inserter.sv
module toh_inserter
    import toh_pkg::*;
#(
    parameter int N_STS = 48
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_a1a2_en,
    input  logic       cfg_b1_en,
    input  logic       cfg_scr_en,
    input  logic       dbg_a1a2_inv,
    input  logic       dbg_b1_inv,
    input  logic       dbg_k2_inv,
    input  logic       in_fp,
    input  logic [7:0] in_data,
    output logic [7:0] out_data,
    output logic       out_fp,
    output logic       out_payload
);
    toh_slot_t  slot;
    toh_beat_t  beat_d, beat_q;
    oh_mode_e   mode;
    logic       active, framing;
    logic [7:0] key, b1_val, ins_byte, cor_byte, fin_byte;

    assign mode    = oh_mode_e'(cfg_mode);
    assign framing = slot.a1 | slot.a2;

    toh_locator #(.N_STS(N_STS)) u_loc (
        .clk(clk), .rst(rst), .in_fp(in_fp), .active(active), .slot(slot)
    );

    toh_scrambler u_scr (
        .clk(clk), .rst(rst), .advance(active),
        .restart(slot.scr_reset), .key(key)
    );

    toh_bip8 u_bip (
        .clk(clk), .rst(rst), .active(active), .sof(slot.sof),
        .byte_in(fin_byte), .parity(b1_val)
    );

    // Overhead substitution by mode
    always_comb begin
        ins_byte = in_data;
        case (mode)
            OH_FRAME_PAR: begin
                if (framing && cfg_a1a2_en) ins_byte = slot.a1 ? FRAMING_HI : FRAMING_LO;
                if (slot.b1 && cfg_b1_en)   ins_byte = b1_val;
            end
            OH_FULL: begin
                if (slot.toh) begin
                    ins_byte = '0;
                    if (framing && cfg_a1a2_en) ins_byte = slot.a1 ? FRAMING_HI : FRAMING_LO;
                    if (slot.b1 && cfg_b1_en)   ins_byte = b1_val;
                end
            end
            default: ins_byte = in_data;
        endcase
    end

    // Debug inversion, then scrambling outside the framing slots
    always_comb begin
        cor_byte = ins_byte;
        if ((framing && dbg_a1a2_inv) || (slot.b1 && dbg_b1_inv) || (slot.k2 && dbg_k2_inv))
            cor_byte = ~ins_byte;
        fin_byte = (cfg_scr_en && !framing) ? (cor_byte ^ key) : cor_byte;
    end

    always_comb begin
        beat_d.data    = active ? fin_byte : in_data;
        beat_d.fp      = active & slot.sof;
        beat_d.payload = active & ~slot.toh;
    end

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= beat_d;
    end

    assign out_data    = beat_q.data;
    assign out_fp      = beat_q.fp;
    assign out_payload = beat_q.payload;
endmodule

// File: rtl/toh_checker.sv
module toh_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_mode,
    input logic       cfg_a1a2_en,
    input logic       dbg_a1a2_inv,
    input logic       in_fp,
    input logic [7:0] in_data,
    input logic [7:0] out_data,
    input logic       out_fp,
    input logic       out_payload
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_data == 8'h00 && !out_fp && !out_payload));

    // R2
    fp_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_fp |=> out_fp);

    // R9
    fp_not_payload_chk: assert property (@(posedge clk) disable iff (rst)
        out_fp |-> !out_payload);

    // R4
    framing_insert_chk: assert property (@(posedge clk) disable iff (rst)
        (in_fp && cfg_mode == 2'd1 && cfg_a1a2_en && !dbg_a1a2_inv) |=> (out_data == 8'hF6));

    // R8
    framing_invert_chk: assert property (@(posedge clk) disable iff (rst)
        (in_fp && cfg_mode == 2'd1 && cfg_a1a2_en && dbg_a1a2_inv) |=> (out_data == 8'h09));

    // R3
    transparent_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_fp && cfg_mode == 2'd0 && !dbg_a1a2_inv) |=> (out_data == $past(in_data)));

    // R6
    full_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_fp && cfg_mode == 2'd2 && !cfg_a1a2_en && !dbg_a1a2_inv) |=> (out_data == 8'h00));
endmodule

bind toh_inserter toh_checker u_chk (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_a1a2_en(cfg_a1a2_en),
    .dbg_a1a2_inv(dbg_a1a2_inv), .in_fp(in_fp), .in_data(in_data),
    .out_data(out_data), .out_fp(out_fp), .out_payload(out_payload)
);

// File: tb/tb_toh_inserter.sv
`timescale 1ns/1ps
module tb_toh_inserter;
    localparam int N       = 2;
    localparam int ROW_LEN = 90 * N;
    localparam int FRAME   = 9 * ROW_LEN;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'd0;
    logic       cfg_a1a2_en = 1'b0, cfg_b1_en = 1'b0, cfg_scr_en = 1'b0;
    logic       dbg_a1a2_inv = 1'b0, dbg_b1_inv = 1'b0, dbg_k2_inv = 1'b0;
    logic       in_fp = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [7:0] out_data;
    logic       out_fp, out_payload;

    always #5 clk = ~clk;

    toh_inserter #(.N_STS(N)) dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_a1a2_en(cfg_a1a2_en),
        .cfg_b1_en(cfg_b1_en), .cfg_scr_en(cfg_scr_en), .dbg_a1a2_inv(dbg_a1a2_inv),
        .dbg_b1_inv(dbg_b1_inv), .dbg_k2_inv(dbg_k2_inv), .in_fp(in_fp),
        .in_data(in_data), .out_data(out_data), .out_fp(out_fp), .out_payload(out_payload)
    );

    int          n_vec = 0, n_bad = 0;
    bit          finished = 0;
    // reference model state
    int          m_row, m_col;
    bit          m_locked;
    bit    [6:0] m_scr;
    bit    [7:0] m_acc, m_b1;
    bit          have_exp;
    bit    [7:0] e_data;
    bit          e_fp, e_pay;
    string       e_tag;
    int unsigned lcg = 32'h1234_5678;

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req, input string what);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: got %02h expected %02h", req, what, $time, got, exp);
        end
    endtask

    task automatic compare();
        if (have_exp) begin
            check(out_data, e_data, e_tag, "data");
            check({7'd0, out_fp}, {7'd0, e_fp}, "R2", "frame flag");
            check({7'd0, out_payload}, {7'd0, e_pay}, "R9", "payload flag");
        end
    endtask

    task automatic model(input bit fp, input bit [7:0] d);
        bit a1p, a2p, b1p, k2p, tohp;
        bit [7:0] b, key;
        bit [6:0] s;
        if (fp) begin m_row = 0; m_col = 0; end
        if (!(fp || m_locked)) begin
            e_data = d; e_fp = 0; e_pay = 0; e_tag = "R2";
            return;
        end
        a1p  = (m_row == 0) && (m_col < N);
        a2p  = (m_row == 0) && (m_col >= N) && (m_col < 2 * N);
        b1p  = (m_row == 1) && (m_col == 0);
        k2p  = (m_row == 4) && (m_col == 2 * N);
        tohp = (m_col < 3 * N);
        b = d; e_tag = "R3";
        if (cfg_mode == 2'd1) begin
            if ((a1p || a2p) && cfg_a1a2_en) begin b = a1p ? 8'hF6 : 8'h28; e_tag = "R4"; end
            if (b1p && cfg_b1_en) begin b = m_b1; e_tag = "R5"; end
        end else if (cfg_mode == 2'd2 && tohp) begin
            b = 8'h00; e_tag = "R6";
            if ((a1p || a2p) && cfg_a1a2_en) b = a1p ? 8'hF6 : 8'h28;
            if (b1p && cfg_b1_en) begin b = m_b1; e_tag = "R5"; end
        end
        if (((a1p || a2p) && dbg_a1a2_inv) || (b1p && dbg_b1_inv) || (k2p && dbg_k2_inv)) begin
            b = ~b; e_tag = "R8";
        end
        s = (m_row == 0 && m_col == 2 * N) ? 7'h7F : m_scr;
        for (int i = 7; i >= 0; i--) begin
            key[i] = s[6];
            s = {s[5:0], s[6] ^ s[5]};
        end
        m_scr = s;
        if (cfg_scr_en && !(a1p || a2p)) begin
            b = b ^ key;
            if (e_tag == "R3") e_tag = "R7";
        end
        if (m_row == 0 && m_col == 0) begin m_b1 = m_acc; m_acc = b; end
        else m_acc = m_acc ^ b;
        e_data = b;
        e_fp   = (m_row == 0 && m_col == 0);
        e_pay  = !tohp;
        m_col++;
        if (m_col == ROW_LEN) begin m_col = 0; m_row = (m_row == 8) ? 0 : m_row + 1; end
        m_locked = 1;
    endtask

    task automatic step(input bit fp, input bit [7:0] d);
        compare();
        in_fp = fp; in_data = d;
        model(fp, d);
        have_exp = 1;
        @(negedge clk);
    endtask

    function automatic bit [7:0] pat(input int kind);
        if (kind == 1) return 8'h00;
        if (kind == 2) return 8'hFF;
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg[23:16];
    endfunction

    task automatic scenario(input logic [1:0] mode, input bit a1e, input bit b1e, input bit se,
                            input bit ia, input bit ib, input bit ik, input int kind,
                            input int pre, input int realign);
        compare();
        have_exp = 0;
        rst = 1; in_fp = 0; in_data = 8'h00;
        cfg_mode = mode; cfg_a1a2_en = a1e; cfg_b1_en = b1e; cfg_scr_en = se;
        dbg_a1a2_inv = ia; dbg_b1_inv = ib; dbg_k2_inv = ik;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_data, 8'h00, "R1", "reset data");
        check({7'd0, out_fp}, 8'h00, "R1", "reset fp");
        check({7'd0, out_payload}, 8'h00, "R1", "reset payload");
        rst = 0;
        m_row = 0; m_col = 0; m_locked = 0; m_scr = 7'h7F; m_acc = 0; m_b1 = 0;
        // R2: pre-lock bytes pass unchanged
        for (int i = 0; i < pre; i++) step(1'b0, pat(kind));
        // R10: optional realigning pulse mid-stream
        for (int i = 0; i < 3 * FRAME; i++) step(i == 0 || i == realign, pat(kind));
        compare();
        have_exp = 0;
    endtask

    initial begin
        @(negedge clk);
        scenario(2'd0, 1, 1, 0, 0, 0, 0, 0, 5, -1);     // R2 R3
        scenario(2'd3, 1, 1, 1, 0, 0, 0, 0, 0, -1);     // R3 R7
        scenario(2'd1, 1, 1, 1, 0, 0, 0, 0, 2, -1);     // R4 R5 R7
        scenario(2'd1, 0, 1, 0, 0, 0, 0, 2, 0, -1);     // R4 disabled, R5
        scenario(2'd2, 1, 1, 1, 0, 0, 0, 0, 0, -1);     // R6 R7
        scenario(2'd2, 0, 0, 0, 0, 0, 0, 2, 0, -1);     // R6 zeros
        scenario(2'd1, 1, 1, 1, 1, 1, 1, 0, 0, -1);     // R8 with scrambling
        scenario(2'd0, 0, 0, 0, 1, 1, 1, 1, 0, -1);     // R8 transparent
        scenario(2'd1, 1, 1, 1, 0, 0, 0, 0, 0, FRAME + 1000); // R10
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule